// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Status Flags

The block takes two byte operands and a five-bit operation code and produces a byte result. It also holds six status flags in a register: carry, zero, negative, overflow, sign and half-carry. The result path is purely combinational.

The flags are written on a clock edge when the valid strobe is high. Each operation writes only the flags it affects and leaves the others as they were. The stored carry is the carry input for the carrying add and subtract and for the two rotates, so a chain of such operations carries from one byte to the next through the flag register.

Typical use is an execute stage. The stage presents the operands and the code, takes the result in the same cycle, and raises valid when the flag update is to commit.

Top module: `alu8_status`

## Requirements
- R1: An active-low asynchronous reset clears all six flags to 0. The `flags` port packs them as bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S) and bit 5 half-carry (H).
- R2: The flags change only on a rising clock edge with `valid` high. With `valid` low they hold, while `result` still follows the inputs.
- R3: Op 0 gives a+b and op 1 gives a+b+C. Both write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), Z (result is zero) and N (result bit 7).
- R4: Op 2 gives a-b, op 3 gives a-b-C and op 8 gives 0-a. All three write C (borrow out of bit 7), H (borrow into bit 4), V (signed overflow), Z and N.
- R5: Op 4 (AND), op 5 (OR) and op 6 (XOR) clear V, write Z and N, and hold C and H.
- R6: Op 7 gives 0xFF-a. It sets C to 1, clears V, writes Z and N, and holds H.
- R7: Op 9 gives a+1 and op 10 gives a-1. V is set only when the result is 0x80 (op 9) or 0x7F (op 10). Z and N are written, and C and H are held.
- R8: Op 11 shifts left with 0 into bit 0. Op 13 rotates left with the stored C into bit 0. Both load C from a bit 7 and H from a bit 3.
- R9: Op 12 shifts right with 0 into bit 7. Op 14 rotates right with the stored C into bit 7. Op 15 shifts right and keeps bit 7. All three load C from a bit 0 and hold H.
- R10: For ops 11 to 15, V equals N XOR C after the shift. For every operation that writes flags, S equals N XOR V.
- R11: Op 16 swaps the nibbles of a. Codes 17 to 31 pass a through. None of these codes changes any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Commit the flag update on this edge |
| op | input | 5 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| flags | output | 6 | Registered flags {H,S,V,N,Z,C} |

## Verification
Within one cycle, the carrying operations (ops 1, 3, 13 and 14) read the stored carry to form the result while also producing the carry that the same edge writes back. The bench provokes this with random back-to-back streams in which most cycles commit. It also sets up directed chains: a complement to force C=1, then a carrying add, then rotates. Each result is judged against a model that uses the flag value committed on the previous edge, and the flags are checked after the edge against the newly computed value.

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [4:0] op,
  input  logic [7:0] a,
  input  logic [7:0] b,
  output logic [7:0] result,
  output logic [5:0] flags
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7;
  localparam logic [4:0] OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11;
  localparam logic [4:0] OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15;
  localparam logic [4:0] OP_SWP = 5'd16;

  logic [5:0] flags_q, flags_d;
  logic       c_old;
  logic [8:0] add9, sub9;
  logic [7:0] sx, sy, r;
  logic       c_n, h_n, v_n, wr_c, wr_h, wr_zn;

  assign c_old = flags_q[0];
  assign sx    = (op == OP_NEG) ? 8'h00 : a;
  assign sy    = (op == OP_NEG) ? a : b;
  assign add9  = {1'b0, a} + {1'b0, b} + {8'd0, (op == OP_ADC) & c_old};
  assign sub9  = {1'b0, sx} - {1'b0, sy} - {8'd0, (op == OP_SBC) & c_old};

  always_comb begin
    r = a; c_n = c_old; h_n = flags_q[5]; v_n = flags_q[3];
    wr_c = 1'b0; wr_h = 1'b0; wr_zn = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        r = add9[7:0]; c_n = add9[8]; wr_c = 1'b1; wr_h = 1'b1;
        h_n = (a[3] & b[3]) | (b[3] & ~r[3]) | (~r[3] & a[3]);
        v_n = (a[7] & b[7] & ~r[7]) | (~a[7] & ~b[7] & r[7]);
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        r = sub9[7:0]; c_n = sub9[8]; wr_c = 1'b1; wr_h = 1'b1;
        h_n = (~sx[3] & sy[3]) | (sy[3] & r[3]) | (r[3] & ~sx[3]);
        v_n = (sx[7] & ~sy[7] & ~r[7]) | (~sx[7] & sy[7] & r[7]);
      end
      OP_AND: begin r = a & b; v_n = 1'b0; end
      OP_OR:  begin r = a | b; v_n = 1'b0; end
      OP_XOR: begin r = a ^ b; v_n = 1'b0; end
      OP_COM: begin r = ~a; c_n = 1'b1; v_n = 1'b0; wr_c = 1'b1; end
      OP_INC: begin r = a + 8'd1; v_n = (r == 8'h80); end
      OP_DEC: begin r = a - 8'd1; v_n = (r == 8'h7F); end
      OP_LSL, OP_ROL: begin
        r = {a[6:0], (op == OP_ROL) & c_old};
        c_n = a[7]; h_n = a[3]; wr_c = 1'b1; wr_h = 1'b1;
        v_n = r[7] ^ a[7];
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        r = {(op == OP_ROR) ? c_old : ((op == OP_ASR) & a[7]), a[7:1]};
        c_n = a[0]; wr_c = 1'b1;
        v_n = r[7] ^ a[0];
      end
      OP_SWP:  begin r = {a[3:0], a[7:4]}; wr_zn = 1'b0; end
      default: begin r = a; wr_zn = 1'b0; end
    endcase
  end

  always_comb begin
    flags_d = flags_q;
    if (wr_zn) begin
      flags_d[1] = (r == 8'h00);
      flags_d[2] = r[7];
      flags_d[3] = v_n;
      flags_d[4] = r[7] ^ v_n;
    end
    if (wr_c) flags_d[0] = c_n;
    if (wr_h) flags_d[5] = h_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= 6'd0;
    else if (valid) flags_q <= flags_d;
  end

  assign result = r;
  assign flags  = flags_q;
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid,
  input logic [4:0] op,
  input logic [7:0] a,
  input logic [7:0] result,
  input logic [5:0] flags
);
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> flags == 6'd0);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flags));

  assert_logic_v_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op == 5'd4 || op == 5'd5 || op == 5'd6) |=> !flags[3]);

  assert_com_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == 5'd7 |=> flags[0] && !flags[3]);

  assert_incdec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op == 5'd9 || op == 5'd10) |=>
      flags[0] == $past(flags[0]) && flags[5] == $past(flags[5]));

  assert_sign_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));

  assert_swap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op >= 5'd16 |=> $stable(flags));
endmodule

bind alu8_status alu8_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .op(op),
  .a(a), .result(result), .flags(flags)
);

// File: tb/test_alu8_status.sv
`timescale 1ns/1ps
module test_alu8_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] a = 8'd0, b = 8'd0;
  logic [7:0] result;
  logic [5:0] flags;
  logic [5:0] mflags;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  alu8_status i_alu8_status (.clk(clk), .rst_n(rst_n), .valid(valid), .op(op),
                             .a(a), .b(b), .result(result), .flags(flags));

  always #10 clk = ~clk;

  function automatic string tag(input logic [4:0] o);
    case (o)
      5'd0, 5'd1:          return "R3";
      5'd2, 5'd3, 5'd8:    return "R4";
      5'd4, 5'd5, 5'd6:    return "R5";
      5'd7:                return "R6";
      5'd9, 5'd10:         return "R7";
      5'd11, 5'd13:        return "R8";
      5'd12, 5'd14, 5'd15: return "R9";
      default:             return "R11";
    endcase
  endfunction

  // returns {result, next flags} ; flags = {H,S,V,N,Z,C}
  function automatic logic [13:0] model(input logic [4:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [5:0] f);
    int s, h, sv;
    logic [7:0] r;
    logic c = f[0], hh = f[5], v = f[3], zn = 1'b1;
    int ci;
    r = x;
    ci = ((o == 5'd1 || o == 5'd3) && f[0]) ? 1 : 0;
    case (o)
      5'd0, 5'd1: begin
        s = int'(x) + int'(y) + ci; r = s[7:0]; c = s > 255;
        hh = (int'(x[3:0]) + int'(y[3:0]) + ci) > 15;
        sv = int'($signed(x)) + int'($signed(y)) + ci; v = (sv > 127) || (sv < -128);
      end
      5'd2, 5'd3, 5'd8: begin
        logic [7:0] p, q;
        p = (o == 5'd8) ? 8'd0 : x; q = (o == 5'd8) ? x : y;
        s = int'(p) - int'(q) - ci; r = s[7:0]; c = s < 0;
        h = int'(p[3:0]) - int'(q[3:0]) - ci; hh = h < 0;
        sv = int'($signed(p)) - int'($signed(q)) - ci; v = (sv > 127) || (sv < -128);
      end
      5'd4: begin r = x & y; v = 0; end
      5'd5: begin r = x | y; v = 0; end
      5'd6: begin r = x ^ y; v = 0; end
      5'd7: begin r = 8'hFF - x; c = 1; v = 0; end
      5'd9:  begin r = x + 8'd1; v = (x == 8'h7F); end
      5'd10: begin r = x - 8'd1; v = (x == 8'h80); end
      5'd11: begin r = x << 1; c = x[7]; hh = x[3]; v = r[7] ^ c; end
      5'd13: begin r = (x << 1) | {7'd0, f[0]}; c = x[7]; hh = x[3]; v = r[7] ^ c; end
      5'd12: begin r = x >> 1; c = x[0]; v = r[7] ^ c; end
      5'd14: begin r = (x >> 1) | {f[0], 7'd0}; c = x[0]; v = r[7] ^ c; end
      5'd15: begin r = (x >> 1) | (x & 8'h80); c = x[0]; v = r[7] ^ c; end
      5'd16: begin r = {x[3:0], x[7:4]}; zn = 0; end
      default: zn = 0;
    endcase
    if (!zn) return {r, f};
    return {r, hh, r[7] ^ v, v, r[7], r == 8'd0, c};
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y, input logic v);
    logic [13:0] m;
    @(negedge clk);
    op = o; a = x; b = y; valid = v;
    #1;
    m = model(o, x, y, mflags);
    check(tag(o), "result", result, m[13:6]);
    @(posedge clk);
    #1;
    if (v) mflags = m[5:0];
    check(v ? tag(o) : "R2", "flags", {2'b00, flags}, {2'b00, mflags});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mflags = 6'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset flags", {2'b00, flags}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    step(5'd0, 8'h80, 8'h80, 1);   // C,V,Z
    step(5'd0, 8'h0F, 8'h01, 1);   // H
    step(5'd7, 8'h5A, 8'h00, 1);   // sets C
    step(5'd1, 8'h10, 8'h20, 1);   // add with stored carry
    step(5'd2, 8'h00, 8'h01, 1);   // borrow
    step(5'd3, 8'h10, 8'h01, 1);   // subtract with stored borrow
    step(5'd8, 8'h80, 8'h00, 1);
    step(5'd8, 8'h00, 8'h00, 1);
    step(5'd9, 8'h7F, 8'h00, 1);   // R7 overflow
    step(5'd10, 8'h80, 8'h00, 1);
    step(5'd7, 8'h00, 8'h00, 1);
    step(5'd9, 8'hFF, 8'h00, 1);   // R7 carry held at 1
    step(5'd4, 8'hF0, 8'h0F, 1);
    step(5'd11, 8'h88, 8'h00, 1);  // R8 C and H
    step(5'd13, 8'h01, 8'h00, 1);
    step(5'd14, 8'h02, 8'h00, 1);
    step(5'd15, 8'h81, 8'h00, 1);
    step(5'd12, 8'h81, 8'h00, 1);
    step(5'd16, 8'hA5, 8'h00, 1);  // R11
    step(5'd20, 8'h3C, 8'h00, 1);  // R11 undefined code
    step(5'd0, 8'hFF, 8'h01, 0);   // R2 no commit
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] o;
      o = 5'($urandom % 18);
      if (o == 5'd17) o = 5'(17 + $urandom % 15);
      step(o, 8'($urandom), 8'($urandom), ($urandom % 8) != 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule